// File: doc/BRIEF.md
# Table-Driven Dual-Channel State Machine

This block is a finite state machine with no hand-written transition logic. All of its next-state and output behaviour is held in a synchronous lookup table. A machine channel builds the table address from its external inputs and its current state. The registered word that the table returns is the channel's state register and output register together. One table word is read per clock, so each channel takes one transition per cycle. No logic sits between the memory read register and the channel's output pins.

The table has two read ports. Two independent channels, A and B, therefore run the same transition table at the same time, each with its own inputs, state, outputs and step enable. A host write port shares port B and can load or replace any word at run time. This changes the behaviour of both channels without any change to the hardware. While the host writes, channel B holds its state and outputs.

Top module: `ram_fsm_duo`

## Requirements
- R1: The table address for a channel is {inputs[N_IN-1:0], state[M_STATE-1:0]}, with the inputs in the high bits, so the table holds 2^(N_IN+M_STATE) words. Each word is {outputs[K_OUT-1:0], next_state[M_STATE-1:0]}, with the next state in the low bits.
- R2: On a rising clock edge where a channel steps, its state becomes the next-state field and its outputs become the output field of the word at that channel's address in that cycle. The new values are visible after that edge.
- R3: While rst is high at a rising edge, each channel's state becomes RESET_STATE and its outputs become zero after that edge, whatever the table contents, step enables and inputs.
- R4: When a channel's step enable is low at a rising edge (and rst is low), that channel's state and outputs keep their values.
- R5: The two channels are independent. Each follows the shared table from its own inputs and its own state, and stepping or holding one has no effect on the other.
- R6: A word written through wr_en, wr_addr and wr_data at a rising edge is used by any channel read at a later edge, so rewriting the table changes the machine behaviour.
- R7: While wr_en is high at a rising edge, the write is performed and channel B holds its state and outputs, even if its step enable is high.
- R8: If channel A reads the address being written in the same cycle, it receives the word stored before the write (read-first).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of both channels |
| wr_en | input | 1 | Host table write strobe |
| wr_addr | input | N_IN+M_STATE | Table word address for the write |
| wr_data | input | K_OUT+M_STATE | Word to store: {outputs, next_state} |
| a_step | input | 1 | Channel A step enable |
| a_in | input | N_IN | Channel A external inputs |
| a_out | output | K_OUT | Channel A outputs |
| a_state | output | M_STATE | Channel A current state |
| b_step | input | 1 | Channel B step enable |
| b_in | input | N_IN | Channel B external inputs |
| b_out | output | K_OUT | Channel B outputs |
| b_state | output | M_STATE | Channel B current state |

## Verification
Assertions check on every cycle that reset loads the reset word into both channels and that a channel with its step enable low, or channel B during a host write, keeps its word unchanged. The correctness of the transitions themselves depends on the table contents, so only the bench scenarios can show it. The bench loads a computed table, sweeps both channels through every table address with different input streams and step patterns, and rewrites the table while the channels run. This shows that new words take effect on the next read and that a collision on the same address returns the old word.

// File: rtl/ram_fsm_pkg.sv
package ram_fsm_pkg;

    // What a channel's word register does at the next edge.
    typedef enum logic [1:0] {
        LANE_RESET = 2'd0,
        LANE_HOLD  = 2'd1,
        LANE_LOAD  = 2'd2
    } lane_act_e;

    // Reset dominates; a blocked or idle channel holds.
    function automatic lane_act_e lane_action(input logic rst,
                                              input logic step,
                                              input logic blocked);
        if (rst)
            return LANE_RESET;
        else if (step && !blocked)
            return LANE_LOAD;
        else
            return LANE_HOLD;
    endfunction

    localparam int NUM_LANES = 2;

endpackage

// File: rtl/ram_fsm_lane.sv
module ram_fsm_lane #(
    parameter int N_IN    = 2,
    parameter int M_STATE = 3,
    parameter int K_OUT   = 3,
    localparam int AW     = N_IN + M_STATE,
    localparam int DW     = K_OUT + M_STATE
) (
    input  logic [N_IN-1:0]    lane_in,
    input  logic [DW-1:0]      word_q,
    output logic [AW-1:0]      rd_addr,
    output logic [K_OUT-1:0]   lane_out,
    output logic [M_STATE-1:0] lane_state
);

    // The registered table word is the state and output register.
    assign lane_state = word_q[M_STATE-1:0];
    assign lane_out   = word_q[DW-1:M_STATE];

    // Inputs in the high address bits, current state in the low bits.
    assign rd_addr = {lane_in, lane_state};

endmodule

// File: rtl/ram_fsm_table.sv
module ram_fsm_table
    import ram_fsm_pkg::*;
#(
    parameter int          AW       = 5,
    parameter int          DW       = 6,
    parameter logic [DW-1:0] RST_WORD = '0,
    localparam int         DEPTH    = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          step_a,
    input  logic [AW-1:0] addr_a,
    output logic [DW-1:0] q_a,
    input  logic          step_b,
    input  logic [AW-1:0] addr_b,
    output logic [DW-1:0] q_b
);

    logic [DW-1:0] mem [DEPTH];
    lane_act_e     act_a, act_b;

    assign act_a = lane_action(rst, step_a, 1'b0);
    assign act_b = lane_action(rst, step_b, wr_en);

    // Host write; the reads below sample the array before this update.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        unique case (act_a)
            LANE_RESET: q_a <= RST_WORD;
            LANE_LOAD:  q_a <= mem[addr_a];
            default:    q_a <= q_a;
        endcase
    end

    always_ff @(posedge clk) begin
        unique case (act_b)
            LANE_RESET: q_b <= RST_WORD;
            LANE_LOAD:  q_b <= mem[addr_b];
            default:    q_b <= q_b;
        endcase
    end

    // R3: reset loads the reset word into both channels
    a_r3_reset_a: assert property (@(posedge clk) rst |=> (q_a == RST_WORD))
        else $error("channel A not at reset word after reset");
    a_r3_reset_b: assert property (@(posedge clk) rst |=> (q_b == RST_WORD))
        else $error("channel B not at reset word after reset");

    // R4: an idle channel keeps its word
    a_r4_hold_a: assert property (@(posedge clk) disable iff (rst)
        !step_a |=> $stable(q_a))
        else $error("channel A changed while idle");
    a_r4_hold_b: assert property (@(posedge clk) disable iff (rst)
        !step_b |=> $stable(q_b))
        else $error("channel B changed while idle");

    // R7: a host write blocks channel B
    a_r7_write_blocks_b: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(q_b))
        else $error("channel B changed during a host write");

endmodule

// File: rtl/ram_fsm_duo.sv
module ram_fsm_duo
    import ram_fsm_pkg::*;
#(
    parameter int N_IN    = 2,
    parameter int M_STATE = 3,
    parameter int K_OUT   = 3,
    parameter logic [M_STATE-1:0] RESET_STATE = '0,
    localparam int AW     = N_IN + M_STATE,
    localparam int DW     = K_OUT + M_STATE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               a_step,
    input  logic [N_IN-1:0]    a_in,
    output logic [K_OUT-1:0]   a_out,
    output logic [M_STATE-1:0] a_state,
    input  logic               b_step,
    input  logic [N_IN-1:0]    b_in,
    output logic [K_OUT-1:0]   b_out,
    output logic [M_STATE-1:0] b_state
);

    localparam logic [DW-1:0] RST_WORD = {{K_OUT{1'b0}}, RESET_STATE};

    logic [N_IN-1:0]    lane_in    [NUM_LANES];
    logic [DW-1:0]      lane_q     [NUM_LANES];
    logic [AW-1:0]      lane_addr  [NUM_LANES];
    logic [K_OUT-1:0]   lane_out   [NUM_LANES];
    logic [M_STATE-1:0] lane_state [NUM_LANES];

    assign lane_in[0] = a_in;
    assign lane_in[1] = b_in;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        ram_fsm_lane #(
            .N_IN   (N_IN),
            .M_STATE(M_STATE),
            .K_OUT  (K_OUT)
        ) u_lane (
            .lane_in   (lane_in[g]),
            .word_q    (lane_q[g]),
            .rd_addr   (lane_addr[g]),
            .lane_out  (lane_out[g]),
            .lane_state(lane_state[g])
        );
    end

    ram_fsm_table #(
        .AW      (AW),
        .DW      (DW),
        .RST_WORD(RST_WORD)
    ) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .step_a (a_step),
        .addr_a (lane_addr[0]),
        .q_a    (lane_q[0]),
        .step_b (b_step),
        .addr_b (lane_addr[1]),
        .q_b    (lane_q[1])
    );

    assign a_out   = lane_out[0];
    assign a_state = lane_state[0];
    assign b_out   = lane_out[1];
    assign b_state = lane_state[1];

endmodule

// File: tb/ram_fsm_duo_bench.sv
module ram_fsm_duo_bench;

    localparam int N = 2;
    localparam int M = 3;
    localparam int K = 3;
    localparam int AW = N + M;
    localparam int DW = K + M;
    localparam int DEPTH = 1 << AW;
    localparam logic [M-1:0] RST_ST = 3'd5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          a_step = 1'b0, b_step = 1'b0;
    logic [N-1:0]  a_in = '0, b_in = '0;
    logic [K-1:0]  a_out, b_out;
    logic [M-1:0]  a_state, b_state;

    int n_vec = 0;
    int n_bad = 0;

    logic [DW-1:0] tbl [DEPTH];
    logic [DW-1:0] exp_a, exp_b;

    always #5 clk = ~clk;

    ram_fsm_duo #(.N_IN(N), .M_STATE(M), .K_OUT(K), .RESET_STATE(RST_ST)) u_ram_fsm_duo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .a_step(a_step), .a_in(a_in), .a_out(a_out), .a_state(a_state),
        .b_step(b_step), .b_in(b_in), .b_out(b_out), .b_state(b_state));

    function automatic logic [DW-1:0] word_f(int adr, int salt);
        return DW'((adr * 13 + 7 + salt * 29) % 64);
    endfunction

    task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] want, string ch);
        n_vec++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s ch%s: got out=%0d st=%0d, expected out=%0d st=%0d",
                     tag, ch, got[DW-1:M], got[M-1:0], want[DW-1:M], want[M-1:0]);
        end
    endtask

    // One clock: drive at negedge, predict, sample 1 ns after the edge.
    task automatic cycle(input logic r, input logic sa, input logic [N-1:0] ia,
                         input logic sb, input logic [N-1:0] ib,
                         input logic we, input logic [AW-1:0] wa,
                         input logic [DW-1:0] wd, input string tag, input logic chk);
        string ta, tb;
        @(negedge clk);
        rst = r; a_step = sa; a_in = ia; b_step = sb; b_in = ib;
        wr_en = we; wr_addr = wa; wr_data = wd;
        ta = tag; tb = tag;
        if (r) begin
            exp_a = {{K{1'b0}}, RST_ST}; exp_b = {{K{1'b0}}, RST_ST};
            ta = "R3"; tb = "R3";
        end else begin
            if (sa) begin
                if (we && wa == {ia, exp_a[M-1:0]}) ta = "R8";
                exp_a = tbl[{ia, exp_a[M-1:0]}];
            end else ta = "R4";
            if (sb && !we) exp_b = tbl[{ib, exp_b[M-1:0]}];
            else tb = we ? "R7" : "R4";
        end
        if (we) tbl[wa] = wd;
        @(posedge clk);
        #1;
        if (chk) begin
            check(ta, {a_out, a_state}, exp_a, "A");
            check(tb, {b_out, b_state}, exp_b, "B");
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        exp_a = '0; exp_b = '0;
        // Load the table with reset held (R3 checks reset state each cycle).
        for (int i = 0; i < DEPTH; i++)
            cycle(1'b1, 1'b1, 2'd3, 1'b1, 2'd1, 1'b1, AW'(i), word_f(i, 0), "R3", 1'b1);

        // R1: word at {in=2, state=5} = address 21, fields {out, next}.
        cycle(1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 5'd21, 6'b101_010, "R3", 1'b1);
        cycle(1'b0, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0, '0, '0, "R1", 1'b0);
        n_vec++;
        if (a_out !== 3'd5 || a_state !== 3'd2) begin
            n_bad++;
            $display("FAIL R1: got out=%0d st=%0d, expected out=5 st=2", a_out, a_state);
        end

        // R2/R5: both channels stepping with distinct input streams.
        for (int c = 0; c < 300; c++)
            cycle(1'b0, 1'b1, N'((c * 3 + (c >> 2)) & 3), 1'b1, N'((c * 7 + 1 + (c >> 3)) & 3),
                  1'b0, '0, '0, (c % 2 == 0) ? "R2" : "R5", 1'b1);

        // R4/R5: irregular step patterns on each channel.
        for (int c = 0; c < 200; c++)
            cycle(1'b0, (c % 3) != 0, N'(c & 3), (c % 5) < 2, N'((c >> 1) & 3),
                  1'b0, '0, '0, "R5", 1'b1);

        // R6/R7/R8: rewrite the table while both channels run; A targets
        // the address being written every fourth cycle.
        for (int c = 0; c < DEPTH * 4; c++) begin
            logic [N-1:0]  ia;
            logic [AW-1:0] wa;
            ia = N'(c & 3);
            wa = (c % 4 == 0) ? {ia, exp_a[M-1:0]} : AW'((c * 5) % DEPTH);
            cycle(1'b0, 1'b1, ia, 1'b1, N'((c >> 2) & 3), 1'b1, wa,
                  word_f(int'(wa), c + 1), "R6", 1'b1);
        end

        // R6: both channels now run on the rewritten table.
        for (int c = 0; c < 200; c++)
            cycle(1'b0, 1'b1, N'((c * 5) & 3), 1'b1, N'((c + (c >> 2)) & 3),
                  1'b0, '0, '0, "R6", 1'b1);

        // R3: mid-run reset with both channels stepping.
        cycle(1'b1, 1'b1, 2'd1, 1'b1, 2'd2, 1'b0, '0, '0, "R3", 1'b1);
        cycle(1'b0, 1'b1, 2'd1, 1'b1, 2'd2, 1'b0, '0, '0, "R2", 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule